// File: doc/BRIEF.md
# Script Register Read-Modify-Write Unit

This unit carries out the register-operation instructions of a SCSI script processor. The processor's fetch and decode logic hands it the two 32-bit words of an instruction together with a one-cycle start strobe. The unit owns a bank of 8-bit registers and a separate first-byte-received register, called the byte register here. It reads one operand, combines it with an 8-bit immediate from the instruction, and writes the result back.

Three function codes choose the data path:
- Code 101 takes the byte register as the source and writes an addressed bank register.
- Code 110 takes the addressed bank register as the source and writes the byte register.
- Code 111 reads, modifies and writes the same bank register.

A 2-bit operator selects one of four operations: pass the immediate, OR, AND, or add.

Every start strobe is answered one cycle later by a single-cycle done pulse. If the instruction does not belong to this class, or is malformed, an illegal flag rises alongside the done pulse and no register changes. A combinational read port and a byte-register output let the surrounding processor observe the bank.

Top module: `scr_regop_unit`

## Requirements
- R1: After reset every bank register and the byte register read zero, and done and illegal are low.
- R2: A start sampled at a clock edge produces done high for exactly the following cycle. Done is low in any cycle that does not follow a start.
- R3: With first word bits 31-30 = 01, bits 29-27 = 101 and operator bits 26-25 = 00, the immediate is written into the addressed bank register and the byte register keeps its value.
- R4: With function 101, operator 01 writes (byte register OR immediate), operator 10 writes (byte register AND immediate) and operator 11 writes (byte register + immediate) into the addressed register.
- R5: With function 110, the result of (addressed register op immediate) goes to the byte register and the bank is unchanged. Operator 00 loads the immediate itself.
- R6: With function 111, the addressed register is replaced by (its own value op immediate), and the byte register keeps its value.
- R7: Add wraps modulo 256 and keeps no carry.
- R8: Function codes 000 to 100 raise illegal together with done and change no register.
- R9: A class field (bits 31-30) other than 01 raises illegal and changes no register.
- R10: A nonzero second instruction word raises illegal and changes no register.
- R11: The register address is taken from bits 21-16 and the immediate from bits 15-8. Bits 24-22 and 7-0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe: execute the presented instruction |
| instr_w0 | input | 32 | First instruction word |
| instr_w1 | input | 32 | Second instruction word (must be zero) |
| rd_addr | input | 6 | Observation read address into the bank |
| rd_data | output | 8 | Bank register at rd_addr (combinational) |
| sfbr | output | 8 | Current byte register value |
| done | output | 1 | Completion pulse, one cycle after start |
| illegal | output | 1 | Rejected-instruction flag, coincident with done |

## Verification
The bench builds the unit with its default parameters: a 6-bit register address and an 8-bit data path. With these values the top entry, 63, and address 0 can both be written directly. They also put the 8-bit wrap of the add operator within reach, through operand pairs whose sum passes 255. A sweep of all 64 entries at the end shows that rejected instructions and junk in the ignored bits left no stray writes.

// File: rtl/scr_regop_pkg.sv
package scr_regop_pkg;

  localparam logic [1:0] CLASS_REGOP  = 2'b01;

  localparam logic [2:0] FN_SFBR2REG  = 3'b101;
  localparam logic [2:0] FN_REG2SFBR  = 3'b110;
  localparam logic [2:0] FN_REG_RMW   = 3'b111;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_OR   = 2'b01,
    OP_AND  = 2'b10,
    OP_ADD  = 2'b11
  } alu_op_e;

  localparam int unsigned CLASS_MSB = 31;
  localparam int unsigned FUNC_MSB  = 29;
  localparam int unsigned OP_MSB    = 26;
  localparam int unsigned ADDR_LSB  = 16;
  localparam int unsigned IMM_LSB   = 8;

endpackage

// File: rtl/scr_regop_decode.sv
module scr_regop_decode
  import scr_regop_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  output logic              legal,
  output logic              src_is_reg,
  output logic              dst_is_reg,
  output alu_op_e           op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] imm
);

  logic [1:0] cls;
  logic [2:0] func;
  logic       func_ok;
  logic       unused_bits;

  always_comb begin
    cls  = w0[CLASS_MSB -: 2];
    func = w0[FUNC_MSB -: 3];
    op   = alu_op_e'(w0[OP_MSB -: 2]);
    addr = w0[ADDR_LSB +: ADDR_W];
    imm  = w0[IMM_LSB +: DATA_W];

    func_ok = (func == FN_SFBR2REG) || (func == FN_REG2SFBR) || (func == FN_REG_RMW);
    legal   = (cls == CLASS_REGOP) && func_ok && (w1 == '0);

    src_is_reg = (func != FN_SFBR2REG);
    dst_is_reg = (func != FN_REG2SFBR);
  end

  assign unused_bits = ^{w0[24:22], w0[7:0]};

endmodule

// File: rtl/scr_regop_alu.sv
module scr_regop_alu
  import scr_regop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_PASS: y = imm;
      OP_OR:   y = a | imm;
      OP_AND:  y = a & imm;
      OP_ADD:  y = a + imm;
      default: y = imm;
    endcase
  end

endmodule

// File: rtl/scr_regop_bank.sv
module scr_regop_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (we) begin
      mem_d[waddr] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata))); // R3

endmodule

// File: rtl/scr_regop_unit.sv
module scr_regop_unit
  import scr_regop_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr_w0,
  input  logic [WORD_W-1:0] instr_w1,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sfbr,
  output logic              done,
  output logic              illegal
);

  logic              dec_legal;
  logic              dec_src_reg;
  logic              dec_dst_reg;
  alu_op_e           dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_imm;

  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_y;

  logic              exec_en;
  logic              we_reg;
  logic              we_sfbr;

  logic [DATA_W-1:0] sfbr_q, sfbr_d;
  logic              done_q, done_d;
  logic              ill_q, ill_d;

  scr_regop_decode #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dec (
    .w0(instr_w0), .w1(instr_w1),
    .legal(dec_legal), .src_is_reg(dec_src_reg), .dst_is_reg(dec_dst_reg),
    .op(dec_op), .addr(dec_addr), .imm(dec_imm)
  );

  scr_regop_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(we_reg), .waddr(dec_addr), .wdata(alu_y),
    .raddr_a(dec_addr), .rdata_a(reg_val),
    .raddr_b(rd_addr), .rdata_b(rd_data)
  );

  scr_regop_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .op(dec_op), .a(alu_a), .imm(dec_imm), .y(alu_y)
  );

  always_comb begin
    alu_a   = dec_src_reg ? reg_val : sfbr_q;
    exec_en = start && dec_legal;
    we_reg  = exec_en && dec_dst_reg;
    we_sfbr = exec_en && !dec_dst_reg;
    sfbr_d  = we_sfbr ? alu_y : sfbr_q;
    done_d  = start;
    ill_d   = start && !dec_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfbr_q <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      sfbr_q <= sfbr_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  assign sfbr    = sfbr_q;
  assign done    = done_q;
  assign illegal = ill_q;

  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R2
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done); // R8
  AST_REJECT_KEEPS_SFBR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dec_legal) |=> $stable(sfbr)); // R9
  AST_REG_DEST_KEEPS_SFBR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dec_legal && dec_dst_reg) |=> $stable(sfbr)); // R6

endmodule

// File: tb/sim_scr_regop_unit.sv
`timescale 1ns/1ps
module sim_scr_regop_unit;

  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [31:0]   w0, w1;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] sfbr;
  logic          done;
  logic          illegal;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] exp_sfbr;

  scr_regop_unit #(.WORD_W(32), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_w0(w0), .instr_w1(w1),
    .rd_addr(rd_addr), .rd_data(rd_data), .sfbr(sfbr), .done(done), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [1:0] cls, input logic [2:0] fn,
                                      input logic [1:0] op, input logic [5:0] a,
                                      input logic [7:0] im);
    return {cls, fn, op, 3'b000, a, im, 8'h00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int a);
    rd_addr = AW'(a);
    #1;
    chk(tag, 32'(rd_data), 32'(exp_mem[a]));
  endtask

  task automatic run(input string tag, input logic [31:0] i0, input logic [31:0] i1,
                     input bit exp_ill);
    @(negedge clk);
    w0 = i0; w1 = i1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; w0 = '0; w1 = '0;
    chk({tag, " R2 done pulse"}, 32'(done), 32'd1);
    chk({tag, " illegal flag"}, 32'(illegal), 32'(exp_ill));
    @(negedge clk);
    chk({tag, " R2 done falls"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 sfbr", 32'(sfbr), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 illegal", 32'(illegal), 32'd0);
    chk_reg("R1 reg0", 0);
    chk_reg("R1 reg63", 63);
  endtask

  task automatic t_write_imm();
    run("R3", mk(2'b01, 3'b101, 2'b00, 6'd5, 8'hA5), '0, 1'b0);
    exp_mem[5] = 8'hA5;
    chk_reg("R3 reg5", 5);
    chk("R3 sfbr kept", 32'(sfbr), 32'(exp_sfbr));
  endtask

  task automatic t_load_sfbr();
    run("R5 load", mk(2'b01, 3'b110, 2'b00, 6'd5, 8'h3C), '0, 1'b0);
    exp_sfbr = 8'h3C;
    chk("R5 sfbr loaded", 32'(sfbr), 32'(exp_sfbr));
    chk_reg("R5 reg5 kept", 5);
  endtask

  task automatic t_sfbr_ops();
    run("R4 or", mk(2'b01, 3'b101, 2'b01, 6'd7, 8'h81), '0, 1'b0);
    exp_mem[7] = 8'hBD;
    chk_reg("R4 or result", 7);
    run("R4 and", mk(2'b01, 3'b101, 2'b10, 6'd8, 8'h0F), '0, 1'b0);
    exp_mem[8] = 8'h0C;
    chk_reg("R4 and result", 8);
    run("R4 add", mk(2'b01, 3'b101, 2'b11, 6'd9, 8'h10), '0, 1'b0);
    exp_mem[9] = 8'h4C;
    chk_reg("R4 add result", 9);
    run("R7 add wrap", mk(2'b01, 3'b101, 2'b11, 6'd10, 8'hF0), '0, 1'b0);
    exp_mem[10] = 8'h2C;
    chk_reg("R7 sfbr add wrap", 10);
  endtask

  task automatic t_rmw();
    run("R6 add", mk(2'b01, 3'b111, 2'b11, 6'd5, 8'h70), '0, 1'b0);
    exp_mem[5] = 8'h15;
    chk_reg("R7 rmw add wrap", 5);
    run("R6 and", mk(2'b01, 3'b111, 2'b10, 6'd5, 8'hF0), '0, 1'b0);
    exp_mem[5] = 8'h10;
    chk_reg("R6 rmw and", 5);
    run("R6 or", mk(2'b01, 3'b111, 2'b01, 6'd5, 8'h03), '0, 1'b0);
    exp_mem[5] = 8'h13;
    chk_reg("R6 rmw or", 5);
    chk("R6 sfbr kept", 32'(sfbr), 32'(exp_sfbr));
  endtask

  task automatic t_to_sfbr();
    run("R5 or", mk(2'b01, 3'b110, 2'b01, 6'd5, 8'h40), '0, 1'b0);
    exp_sfbr = 8'h53;
    chk("R5 sfbr = reg or imm", 32'(sfbr), 32'(exp_sfbr));
    chk_reg("R5 source reg kept", 5);
    run("R5 add", mk(2'b01, 3'b110, 2'b11, 6'd7, 8'h50), '0, 1'b0);
    exp_sfbr = 8'h0D;
    chk("R5 sfbr = reg add imm", 32'(sfbr), 32'(exp_sfbr));
  endtask

  task automatic t_illegal_func();
    for (int f = 0; f < 5; f++) begin
      run("R8", mk(2'b01, 3'(f), 2'b00, 6'd5, 8'hFF), '0, 1'b1);
      chk_reg("R8 reg5 kept", 5);
      chk("R8 sfbr kept", 32'(sfbr), 32'(exp_sfbr));
    end
  endtask

  task automatic t_bad_class();
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin
        run("R9", mk(2'(c), 3'b101, 2'b00, 6'd5, 8'hEE), '0, 1'b1);
        chk_reg("R9 reg5 kept", 5);
        run("R9 sfbr", mk(2'(c), 3'b110, 2'b00, 6'd5, 8'hEE), '0, 1'b1);
        chk("R9 sfbr kept", 32'(sfbr), 32'(exp_sfbr));
      end
    end
  endtask

  task automatic t_bad_w1();
    run("R10", mk(2'b01, 3'b111, 2'b01, 6'd5, 8'hFF), 32'h0000_0001, 1'b1);
    chk_reg("R10 reg5 kept", 5);
    run("R10 high", mk(2'b01, 3'b110, 2'b00, 6'd5, 8'h77), 32'h8000_0000, 1'b1);
    chk("R10 sfbr kept", 32'(sfbr), 32'(exp_sfbr));
  endtask

  task automatic t_fields();
    run("R11 top", mk(2'b01, 3'b101, 2'b00, 6'd63, 8'h5A) | 32'h01C0_00FF, '0, 1'b0);
    exp_mem[63] = 8'h5A;
    chk_reg("R11 reg63", 63);
    run("R11 zero", mk(2'b01, 3'b101, 2'b00, 6'd0, 8'hC3) | 32'h0140_0081, '0, 1'b0);
    exp_mem[0] = 8'hC3;
    chk_reg("R11 reg0", 0);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < DEPTH; a++) begin
      chk_reg("R11 sweep", a);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
    exp_sfbr = '0;
    start = 1'b0; w0 = '0; w1 = '0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_imm();
    t_load_sfbr();
    t_sfbr_ops();
    t_rmw();
    t_to_sfbr();
    t_illegal_func();
    t_bad_class();
    t_bad_w1();
    t_fields();
    t_sweep();
    finished = 1;
    summary();
    $finish;
  end

endmodule